// File: doc/BRIEF.md
# SD Host Global Register Front End

This block sits in front of a two-slot SD host controller. It decodes a 4 KiB register window that a 32-bit bus reaches with whole-word accesses. The lowest 256 bytes hold the controller-wide registers:

- a controller info word that reports which slots exist and carries a self-clearing controller reset request;
- a debounce word;
- shadow copies of each slot's capability and maximum-current words, which are driven out to the slots;
- an interrupt status word that mirrors one interrupt line from each slot;
- plain storage for the other words.

Each following 256-byte page is routed to one slot's register port. Pages above the last slot are empty.

Every request is answered exactly one cycle later on a registered response. The response carries the read data, or zero for writes, empty space and faults. A response control machine has three states:

- `RSP_IDLE`: no response this cycle.
- `RSP_DATA`: a good response.
- `RSP_FAULT`: a rejected access.

From any state, a cycle with no request moves the machine to `RSP_IDLE`. A well-formed request moves it to `RSP_DATA`. A misaligned request, or one without all byte enables set, moves it to `RSP_FAULT`.

Top module: `sdhc_glue_regs`

## Requirements
- R1: After reset:
  - word 0x00 reads 0x00010000, with bit 17 also set when NSLOT is 2;
  - word 0x04 reads 0x00000005;
  - each present slot's capability word (0x10, 0x20) reads CAP_RESET;
  - every other word below 0x100 reads 0;
  - `irq_out` and `ctrl_soft_rst` are low.
- R2: A write to 0x00 stores bits 31..1 as written and bit 0 as zero. A write there with bit 0 set raises `ctrl_soft_rst` for exactly the cycle after the write. A write with bit 0 clear does not raise it.
- R3: Every word below 0x100, except 0x00 and 0xFC, reads back the last value written to it.
- R4: Words 0x10 and 0x18 hold slot 0's capability and maximum-current values, and words 0x20 and 0x28 hold slot 1's.
  - They appear on `slot_cap` and `slot_curr`, slot n in bits [32n+31:32n].
  - These outputs change only after a write.
- R5: Bit n of word 0xFC equals `slot_irq_in[n]` as sampled at the previous clock edge. Writes to 0xFC leave it unchanged.
- R6: `irq_out` is high exactly when word 0xFC has any bit set.
- R7: Accesses in page n+1 (addresses (n+1)*0x100 to (n+1)*0x100+0xFF) go to slot n's port.
  - `slot_req[n]` is raised in the same cycle as the request, and no other `slot_req` bit is raised.
  - `slot_off` carries the address bits [7:0], and `slot_we` and `slot_wdata` carry the request's write flag and data.
  - A read's response returns slot n's `slot_rdata` word from the request cycle.
- R8: Aligned full-word accesses at or above (NSLOT+1)*0x100 raise no `slot_req` bit and no error. They change no register and read as zero.
- R9: An access with address bits [1:0] not zero, or with `req_be` not 4'hF, is rejected.
  - It gets `rsp_err` high and `rsp_rdata` zero in its response cycle.
  - It raises no `slot_req` bit and changes no register.
- R10: `rsp_valid` is high in the cycle after each request and low in the cycle after a cycle without one. Write responses return zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address within the window |
| req_be | input | 4 | Byte enables; must be all ones |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present (one cycle after request) |
| rsp_err | output | 1 | Response reports a rejected access |
| rsp_rdata | output | 32 | Response read data |
| slot_req | output | NSLOT | Per-slot port select |
| slot_we | output | 1 | Slot port write flag |
| slot_off | output | 8 | Offset within the slot page |
| slot_wdata | output | 32 | Slot port write data |
| slot_rdata | input | 32*NSLOT | Slot port read data, slot n in bits [32n+31:32n] |
| slot_cap | output | 32*NSLOT | Capability values driven to the slots |
| slot_curr | output | 32*NSLOT | Maximum-current values driven to the slots |
| slot_irq_in | input | NSLOT | Interrupt level from each slot |
| irq_out | output | 1 | Controller interrupt |
| ctrl_soft_rst | output | 1 | One-cycle controller reset request |

## Verification
The properties take for granted that:
- the request inputs are known, free of X, whenever `req_valid` is high;
- `slot_irq_in` is a clean synchronous level;
- a request lasts a single cycle, so one request never overlaps the response of the one before.

The stimulus drives every input on the falling edge and holds `req_valid` for exactly one cycle per access. It parks all inputs at zero between accesses and changes the interrupt levels only when no request is in flight. Misaligned and partial-enable accesses are issued deliberately, but only as isolated single-cycle requests, so the fault checks see one cause at a time.

// File: rtl/sdhc_glue_pkg.sv
package sdhc_glue_pkg;

    localparam int unsigned MAX_SLOTS  = 2;
    localparam int unsigned NWORD      = 64;
    localparam logic [5:0]  W_INFO     = 6'd0;
    localparam logic [5:0]  W_DEBOUNCE = 6'd1;
    localparam logic [5:0]  W_IRQ      = 6'd63;
    localparam logic [31:0] DEBOUNCE_RST = 32'h0000_0005;

    typedef enum logic [1:0] {
        ACC_GLOBAL,
        ACC_SLOT,
        ACC_VOID,
        ACC_BAD
    } acc_kind_e;

    typedef enum logic [1:0] {
        RSP_IDLE,
        RSP_DATA,
        RSP_FAULT
    } rsp_state_e;

    // Word index of slot n's capability word; maximum-current sits two words on.
    function automatic logic [5:0] cap_word(input int unsigned n);
        return 6'(4 + 4 * n);
    endfunction

    function automatic logic [31:0] word_reset(input logic [5:0] idx,
                                               input int unsigned nslot,
                                               input logic [31:0] cap);
        logic [31:0] v;
        v = '0;
        if (idx == W_INFO) begin
            for (int unsigned n = 0; n < MAX_SLOTS; n++)
                if (n < nslot) v[16 + n] = 1'b1;
        end else if (idx == W_DEBOUNCE) begin
            v = DEBOUNCE_RST;
        end else begin
            for (int unsigned n = 0; n < MAX_SLOTS; n++)
                if (n < nslot && idx == cap_word(n)) v = cap;
        end
        return v;
    endfunction

endpackage

// File: rtl/sdhc_glue_decode.sv
module sdhc_glue_decode
    import sdhc_glue_pkg::*;
#(
    parameter int unsigned NSLOT = 2,
    localparam int unsigned SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic [11:0]   addr,
    input  logic [3:0]    be,
    output acc_kind_e     kind,
    output logic [5:0]    widx,
    output logic [SW-1:0] sidx
);

    logic [3:0] page;
    logic [3:0] page_m1;

    always_comb begin
        page    = addr[11:8];
        page_m1 = page - 4'd1;
        widx    = addr[7:2];
        sidx    = page_m1[SW-1:0];
        if (addr[1:0] != 2'b00 || be != 4'hF)
            kind = ACC_BAD;
        else if (page == 4'd0)
            kind = ACC_GLOBAL;
        else if (page <= 4'(NSLOT))
            kind = ACC_SLOT;
        else
            kind = ACC_VOID;
    end

endmodule

// File: rtl/sdhc_glue_gregs.sv
module sdhc_glue_gregs
    import sdhc_glue_pkg::*;
#(
    parameter int unsigned NSLOT     = 2,
    parameter logic [31:0] CAP_RESET = 32'h0570_12B4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [5:0]         wr_idx,
    input  logic [31:0]        wr_data,
    input  logic [5:0]         rd_idx,
    output logic [31:0]        rd_data,
    input  logic [NSLOT-1:0]   irq_in,
    output logic [NSLOT*32-1:0] cap_o,
    output logic [NSLOT*32-1:0] curr_o,
    output logic               irq_o,
    output logic               soft_rst_o
);

    logic [NWORD-1:0][31:0] mem;
    logic                   soft_rst_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < NWORD; w++)
                mem[w] <= word_reset(6'(w), NSLOT, CAP_RESET);
            soft_rst_q <= 1'b0;
        end else begin
            if (wr_en && wr_idx != W_IRQ)
                mem[wr_idx] <= (wr_idx == W_INFO) ? (wr_data & ~32'h1) : wr_data;
            mem[W_IRQ] <= {{(32 - NSLOT){1'b0}}, irq_in};
            soft_rst_q <= wr_en && (wr_idx == W_INFO) && wr_data[0];
        end
    end

    assign rd_data    = mem[rd_idx];
    assign irq_o      = |mem[W_IRQ];
    assign soft_rst_o = soft_rst_q;

    for (genvar n = 0; n < NSLOT; n++) begin : g_slot_shadow
        assign cap_o[n*32 +: 32]  = mem[cap_word(n)];
        assign curr_o[n*32 +: 32] = mem[cap_word(n) + 6'd2];
    end

endmodule

// File: rtl/sdhc_glue_regs.sv
module sdhc_glue_regs
    import sdhc_glue_pkg::*;
#(
    parameter int unsigned NSLOT     = 2,
    parameter logic [31:0] CAP_RESET = 32'h0570_12B4,
    localparam int unsigned SW       = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [11:0]         req_addr,
    input  logic [3:0]          req_be,
    input  logic [31:0]         req_wdata,
    output logic                rsp_valid,
    output logic                rsp_err,
    output logic [31:0]         rsp_rdata,
    output logic [NSLOT-1:0]    slot_req,
    output logic                slot_we,
    output logic [7:0]          slot_off,
    output logic [31:0]         slot_wdata,
    input  logic [NSLOT*32-1:0] slot_rdata,
    output logic [NSLOT*32-1:0] slot_cap,
    output logic [NSLOT*32-1:0] slot_curr,
    input  logic [NSLOT-1:0]    slot_irq_in,
    output logic                irq_out,
    output logic                ctrl_soft_rst
);

    acc_kind_e     kind;
    logic [5:0]    widx;
    logic [SW-1:0] sidx;
    logic [31:0]   greg_rd;
    logic [31:0]   rd_next;
    logic [31:0]   rdata_q;
    rsp_state_e    state_q, state_d;

    sdhc_glue_decode #(.NSLOT(NSLOT)) u_decode (
        .addr (req_addr),
        .be   (req_be),
        .kind (kind),
        .widx (widx),
        .sidx (sidx)
    );

    sdhc_glue_gregs #(.NSLOT(NSLOT), .CAP_RESET(CAP_RESET)) u_gregs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (req_valid && req_write && kind == ACC_GLOBAL),
        .wr_idx     (widx),
        .wr_data    (req_wdata),
        .rd_idx     (widx),
        .rd_data    (greg_rd),
        .irq_in     (slot_irq_in),
        .cap_o      (slot_cap),
        .curr_o     (slot_curr),
        .irq_o      (irq_out),
        .soft_rst_o (ctrl_soft_rst)
    );

    for (genvar n = 0; n < NSLOT; n++) begin : g_slot_sel
        assign slot_req[n] = req_valid && (kind == ACC_SLOT) && (sidx == SW'(n));
    end
    assign slot_we    = req_write;
    assign slot_off   = req_addr[7:0];
    assign slot_wdata = req_wdata;

    // Next-state and captured read data.
    always_comb begin
        state_d = RSP_IDLE;
        rd_next = '0;
        if (req_valid) begin
            unique case (kind)
                ACC_BAD:    state_d = RSP_FAULT;
                ACC_GLOBAL: begin
                    state_d = RSP_DATA;
                    if (!req_write) rd_next = greg_rd;
                end
                ACC_SLOT:   begin
                    state_d = RSP_DATA;
                    if (!req_write) rd_next = slot_rdata[sidx*32 +: 32];
                end
                ACC_VOID:   state_d = RSP_DATA;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            rdata_q <= rd_next;
        end
    end

    // Outputs from the response state.
    always_comb begin
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        rsp_rdata = '0;
        unique case (state_q)
            RSP_IDLE:  ;
            RSP_DATA:  begin
                rsp_valid = 1'b1;
                rsp_rdata = rdata_q;
            end
            RSP_FAULT: begin
                rsp_valid = 1'b1;
                rsp_err   = 1'b1;
            end
            default:   ;
        endcase
    end

endmodule

// File: rtl/sdhc_glue_regs_chk.sv
module sdhc_glue_regs_chk #(
    parameter int unsigned NSLOT = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_write,
    input logic [11:0]         req_addr,
    input logic [3:0]          req_be,
    input logic [31:0]         req_wdata,
    input logic                rsp_valid,
    input logic                rsp_err,
    input logic [31:0]         rsp_rdata,
    input logic [NSLOT-1:0]    slot_req,
    input logic [NSLOT*32-1:0] slot_cap,
    input logic [NSLOT-1:0]    slot_irq_in,
    input logic                irq_out,
    input logic                ctrl_soft_rst
);

    logic bad_req;
    assign bad_req = req_valid && (req_addr[1:0] != 2'b00 || req_be != 4'hF);

    p_fault_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bad_req |=> rsp_err && rsp_rdata == 32'd0);

    p_fault_noslot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bad_req |-> slot_req == '0);

    p_resp_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_resp_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_slot_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_req));

    p_irq_or_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> irq_out == (|$past(slot_irq_in)));

    p_softrst_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_soft_rst |-> $past(req_valid && req_write && req_addr == 12'h000
                                && req_be == 4'hF && req_wdata[0]));

    p_cap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write) |=> $stable(slot_cap));

endmodule

bind sdhc_glue_regs sdhc_glue_regs_chk #(.NSLOT(NSLOT)) u_chk (.*);

// File: tb/sdhc_glue_regs_bench.sv
`timescale 1ns/1ps
module sdhc_glue_regs_bench;

    localparam int unsigned NSLOT = 2;
    localparam logic [31:0] CAPR  = 32'h0570_12B4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic [NSLOT-1:0] slot_req;
    logic        slot_we;
    logic [7:0]  slot_off;
    logic [31:0] slot_wdata;
    logic [NSLOT*32-1:0] slot_rdata, slot_cap, slot_curr;
    logic [NSLOT-1:0] slot_irq_in = '0;
    logic        irq_out, ctrl_soft_rst;

    int n_chk = 0, n_bad = 0;
    logic [31:0] model [64];

    logic [31:0] r_rdata;
    logic        r_err, r_valid, r_we, r_soft;
    logic [NSLOT-1:0] r_sreq;
    logic [7:0]  r_off;
    logic [31:0] r_swd;

    always #2.5 clk = ~clk;

    for (genvar n = 0; n < NSLOT; n++) begin : g_slot_model
        assign slot_rdata[n*32 +: 32] = 32'hC0DE_0000 | (32'(n) << 12) | {24'd0, slot_off};
    end

    sdhc_glue_regs #(.NSLOT(NSLOT), .CAP_RESET(CAPR)) u_sdhc_glue_regs (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic wr, input logic [11:0] a, input logic [31:0] d,
                        input logic [3:0] be);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        #1;
        r_sreq = slot_req; r_off = slot_off; r_we = slot_we; r_swd = slot_wdata;
        @(negedge clk);
        r_rdata = rsp_rdata; r_err = rsp_err; r_valid = rsp_valid; r_soft = ctrl_soft_rst;
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; req_be = '0;
    endtask

    function automatic logic [31:0] pat(input int i);
        return (32'h9E37_79B9 * 32'(i + 1)) ^ 32'(i);
    endfunction

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) model[i] = 32'd0;
        model[0] = 32'h0003_0000;
        model[1] = 32'h0000_0005;
        model[4] = CAPR;
        model[8] = CAPR;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state at ports and in every global word
        check("R1 irq_out", 32'(irq_out), 32'd0);
        check("R1 soft_rst", 32'(ctrl_soft_rst), 32'd0);
        check("R1 cap0", slot_cap[31:0], CAPR);
        check("R1 cap1", slot_cap[63:32], CAPR);
        check("R1 curr", slot_curr[31:0] | slot_curr[63:32], 32'd0);
        for (int i = 0; i < 64; i++) begin
            xfer(1'b0, 12'(4 * i), 32'd0, 4'hF);
            check($sformatf("R1 word %0d", i), r_rdata, model[i]);
            check("R10 valid", 32'(r_valid), 32'd1);
        end

        // R2/R3: write a pattern to every word
        for (int i = 0; i < 64; i++) begin
            xfer(1'b1, 12'(4 * i), pat(i), 4'hF);
            check("R10 write data zero", r_rdata, 32'd0);
            if (i == 0) check("R2 soft pulse", 32'(r_soft), 32'd1);
            if (i == 1) check("R2 soft one cycle", 32'(r_soft), 32'd0);
            if (i == 0) model[0] = pat(0) & ~32'h1;
            else if (i != 63) model[i] = pat(i);
        end
        for (int i = 0; i < 64; i++) begin
            xfer(1'b0, 12'(4 * i), 32'd0, 4'hF);
            check($sformatf("R3 readback %0d", i), r_rdata, model[i]);
        end
        xfer(1'b1, 12'h000, 32'h0001_0000, 4'hF);
        check("R2 no pulse bit0 clear", 32'(r_soft), 32'd0);
        model[0] = 32'h0001_0000;

        // R4: shadows on the slot ports
        check("R4 cap0", slot_cap[31:0], model[4]);
        check("R4 curr0", slot_curr[31:0], model[6]);
        check("R4 cap1", slot_cap[63:32], model[8]);
        check("R4 curr1", slot_curr[63:32], model[10]);

        // R5/R6: interrupt mirror
        for (int p = 0; p < 4; p++) begin
            @(negedge clk);
            slot_irq_in = 2'(p);
            @(negedge clk);
            check("R6 irq_out", 32'(irq_out), 32'(p != 0));
            xfer(1'b0, 12'hFC, 32'd0, 4'hF);
            check("R5 irq status", r_rdata, 32'(p));
        end
        @(negedge clk); slot_irq_in = 2'b10;
        xfer(1'b1, 12'hFC, 32'hFFFF_FFFF, 4'hF);
        xfer(1'b0, 12'hFC, 32'd0, 4'hF);
        check("R5 write ignored", r_rdata, 32'h2);
        @(negedge clk); slot_irq_in = 2'b00;
        @(negedge clk);
        check("R6 irq low", 32'(irq_out), 32'd0);

        // R7: sweep both slot pages
        for (int a = 12'h100; a < 12'h300; a += 4) begin
            automatic int n = (a >> 8) - 1;
            automatic logic wr = a[2];
            xfer(wr, 12'(a), 32'(a) ^ 32'h5A5A_0000, 4'hF);
            check("R7 slot_req", 32'(r_sreq), 32'(1 << n));
            check("R7 slot_off", 32'(r_off), 32'(a & 8'hFF));
            check("R7 slot_we", 32'(r_we), 32'(wr));
            check("R7 rdata", r_rdata, wr ? 32'd0
                  : (32'hC0DE_0000 | 32'(n << 12) | 32'(a & 8'hFF)));
            if (wr) check("R7 wdata", r_swd, 32'(a) ^ 32'h5A5A_0000);
        end

        // R8: empty pages
        foreach (model[k]) ;
        begin
            logic [11:0] vaddr [5] = '{12'h300, 12'h3FC, 12'h310, 12'h800, 12'hFFC};
            for (int k = 0; k < 5; k++) begin
                xfer(1'b1, vaddr[k], 32'hDEAD_BEEF, 4'hF);
                check("R8 write no slot", 32'(r_sreq), 32'd0);
                check("R8 write no err", 32'(r_err), 32'd0);
                xfer(1'b0, vaddr[k], 32'd0, 4'hF);
                check("R8 read zero", r_rdata, 32'd0);
                check("R8 read no slot", 32'(r_sreq), 32'd0);
            end
            xfer(1'b0, 12'h010, 32'd0, 4'hF);
            check("R8 cap0 untouched", r_rdata, model[4]);
        end

        // R9: rejected accesses
        begin
            logic [11:0] ba [4] = '{12'h011, 12'h006, 12'h103, 12'h01A};
            logic [3:0]  bb [3] = '{4'h7, 4'hE, 4'h0};
            for (int k = 0; k < 4; k++) begin
                xfer(1'b1, ba[k], 32'h1234_5678, 4'hF);
                check("R9 err misaligned", 32'(r_err), 32'd1);
                check("R9 no slot", 32'(r_sreq), 32'd0);
                check("R9 data zero", r_rdata, 32'd0);
            end
            for (int k = 0; k < 3; k++) begin
                xfer(1'b1, 12'h004, 32'h1234_5678, bb[k]);
                check("R9 err partial be", 32'(r_err), 32'd1);
            end
            xfer(1'b0, 12'h012, 32'd0, 4'hF);
            check("R9 read err", 32'(r_err), 32'd1);
            check("R9 read zero", r_rdata, 32'd0);
            xfer(1'b0, 12'h004, 32'd0, 4'hF);
            check("R9 debounce untouched", r_rdata, model[1]);
            xfer(1'b0, 12'h010, 32'd0, 4'hF);
            check("R9 cap untouched", r_rdata, model[4]);
            check("R9 cap port", slot_cap[31:0], model[4]);
        end

        @(negedge clk);
        check("R10 idle", 32'(rsp_valid), 32'd0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule